// File: doc/BRIEF.md
# Serially Concatenated PPM Encoder

This block turns fixed-size blocks of information bits into a stream of pulse-position slot indices. Each block goes through four stages in a fixed order. First a rate-1/2 four-state feedforward convolutional code, terminated with two zero tail bits. Then a bit interleaver with a multiplicative permutation. Then a rate-1 accumulator. Last, a mapper that turns each group of four accumulated bits into the index of the single pulsed slot out of sixteen.

Information bits enter one per ready/valid handshake, and a start marker flags the first bit of each block. Coded bits are written in natural order into one of two register banks. Each bank can be read or written within a single cycle. While one bank is being filled, the other is read out in permuted order, four addresses per cycle, and one slot index leaves per output handshake. A stalled output holds every stage. No bit is lost or repeated.

Top module: `scppm_encoder`

## Requirements
- R1: After synchronous reset, out_valid is 0 and in_ready is 1.
- R2: For information bits u_t (t = 0..K-1, in arrival order) and state bits s1 (previous input) and s2 (input before that), both 0 at the start of every block, the coder emits the pair p = u^s1^s2 and then q = u^s2. These are coded positions 2t and 2t+1. Two tail steps with u = 0 follow, for N = 2(K+2) coded bits in all.
- R3: The j-th bit fed to the accumulator is the coded bit at position (A·j) mod N. A is the odd multiplier parameter, 13 by default, with N = 32.
- R4: The accumulator output is a_j = x_j ^ a_(j-1), with a_(-1) = 0 at the start of every block, whatever the previous block ended with.
- R5: Output symbol s is the 4-bit value built from a_(4s), a_(4s+1), a_(4s+2), a_(4s+3), with a_(4s) as the MSB. Its value 0..15 is the pulsed slot index.
- R6: While no block is being accepted, bits offered without the start marker are consumed and discarded. A start marker on a bit in the middle of a block has no effect, and the bit is taken as data.
- R7: After the last information bit of a block is accepted, in_ready is low for exactly two cycles while the tail is coded, if the other bank is free.
- R8: A new block is accepted while the previous one is still being emitted. With the output stalled, exactly two blocks are accepted, and in_ready then stays low.
- R9: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_sym holds its value in the next cycle.
- R10: Each block yields exactly N/4 symbols, in order. When no complete block is waiting, out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Information bit offered |
| in_ready | output | 1 | Encoder accepts the offered bit |
| in_bit | input | 1 | Information bit |
| in_sof | input | 1 | Marks the first bit of a block |
| out_valid | output | 1 | Slot index available |
| out_ready | input | 1 | Downstream accepts the slot index |
| out_sym | output | log2(PPM_SLOTS) | Index of the pulsed slot |

## Verification
The bench builds the block with its defaults: 14 information bits, 32 coded bits, 16 slots and permutation multiplier 13. That makes 8 symbols per block. At this size every single-one and every two-one information pattern can be swept, alongside all-zero, all-one and pseudo-random blocks, and each expected symbol is computed arithmetically from the code, permutation and accumulator equations. The short block also fills both banks within a few dozen cycles of held-off output. This brings the full-buffer stall, the tail gap and the bank hand-over into reach early in the run, and the run then continues under a randomly gated output ready.

// File: rtl/scppm_pkg.sv
package scppm_pkg;

    typedef enum logic [1:0] {
        W_SEEK = 2'd0,
        W_DATA = 2'd1,
        W_TAIL = 2'd2
    } wr_state_e;

    typedef struct packed {
        logic s1;
        logic s2;
    } cc_state_t;

    typedef struct packed {
        logic p;
        logic q;
    } cc_pair_t;

    function automatic int unsigned coded_len(input int unsigned info_bits);
        return 2 * (info_bits + 2);
    endfunction

    function automatic cc_pair_t cc_encode(input logic u, input cc_state_t s);
        cc_pair_t r;
        r.p = u ^ s.s1 ^ s.s2;
        r.q = u ^ s.s2;
        return r;
    endfunction

    function automatic cc_state_t cc_next(input logic u, input cc_state_t s);
        cc_state_t r;
        r.s1 = u;
        r.s2 = s.s1;
        return r;
    endfunction

    function automatic int unsigned perm_index(input int unsigned j,
                                               input int unsigned mult,
                                               input int unsigned n);
        return (mult * j) % n;
    endfunction

endpackage

// File: rtl/scppm_outer_enc.sv
module scppm_outer_enc
    import scppm_pkg::*;
#(
    parameter int INFO_BITS = 14,
    parameter int PW        = $clog2(INFO_BITS + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          in_bit,
    input  logic          in_sof,
    input  logic          wr_ok,
    output logic          we,
    output logic [PW-1:0] waddr,
    output cc_pair_t      wpair,
    output logic          wr_done
);

    wr_state_e     st;
    cc_state_t     cs;
    cc_state_t     cs_eff;
    logic [PW-1:0] tcnt;
    logic          take;
    logic          u;

    assign in_ready = wr_ok && (st != W_TAIL);
    assign take     = in_valid && in_ready;
    assign cs_eff   = (st == W_SEEK) ? '0 : cs;
    assign u        = (st == W_TAIL) ? 1'b0 : in_bit;
    assign wpair    = cc_encode(u, cs_eff);
    assign waddr    = (st == W_SEEK) ? '0 : tcnt;
    assign wr_done  = (st == W_TAIL) && (tcnt == PW'(INFO_BITS + 1));

    always_comb begin
        case (st)
            W_SEEK:  we = take && in_sof;
            W_DATA:  we = take;
            W_TAIL:  we = 1'b1;
            default: we = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= W_SEEK;
            cs   <= '0;
            tcnt <= '0;
        end else begin
            case (st)
                W_SEEK: begin
                    if (take && in_sof) begin
                        cs   <= cc_next(in_bit, '0);
                        tcnt <= PW'(1);
                        st   <= W_DATA;
                    end
                end
                W_DATA: begin
                    if (take) begin
                        cs   <= cc_next(in_bit, cs);
                        tcnt <= tcnt + PW'(1);
                        if (tcnt == PW'(INFO_BITS - 1)) st <= W_TAIL;
                    end
                end
                W_TAIL: begin
                    if (wr_done) begin
                        cs   <= '0;
                        tcnt <= '0;
                        st   <= W_SEEK;
                    end else begin
                        cs   <= cc_next(1'b0, cs);
                        tcnt <= tcnt + PW'(1);
                    end
                end
                default: st <= W_SEEK;
            endcase
        end
    end

    AST_TAIL_TWO_CYCLES: assert property (@(posedge clk) disable iff (rst)
        (st == W_TAIL) && $past(st == W_TAIL) |-> wr_done); // R7
    AST_TAIL_BANK_OPEN: assert property (@(posedge clk) disable iff (rst)
        (st == W_TAIL) |-> wr_ok); // R8
    AST_SEEK_STATE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (st == W_SEEK) |-> (cs == '0) && (tcnt == '0)); // R2

endmodule

// File: rtl/scppm_ilv_store.sv
module scppm_ilv_store
    import scppm_pkg::*;
#(
    parameter int CODE_BITS = 32,
    parameter int SYM_BITS  = 4,
    parameter int AW        = $clog2(CODE_BITS),
    parameter int PW        = AW - 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  logic [PW-1:0]                waddr,
    input  cc_pair_t                     wpair,
    input  logic                         wr_done,
    output logic                         wr_ok,
    input  logic [SYM_BITS-1:0][AW-1:0]  raddr,
    output logic [SYM_BITS-1:0]          rbits,
    input  logic                         rd_done,
    output logic                         rd_ok
);

    logic [CODE_BITS-1:0] bank [2];
    logic [1:0]           full;
    logic                 wsel;
    logic                 rsel;
    logic [AW-1:0]        wbase;

    assign wbase = {waddr, 1'b0};
    assign wr_ok = !full[wsel];
    assign rd_ok = full[rsel];

    always_ff @(posedge clk) begin
        if (we) begin
            bank[wsel][wbase]          <= wpair.p;
            bank[wsel][wbase + AW'(1)] <= wpair.q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= '0;
            wsel <= 1'b0;
            rsel <= 1'b0;
        end else begin
            if (wr_done) begin
                full[wsel] <= 1'b1;
                wsel       <= ~wsel;
            end
            if (rd_done) begin
                full[rsel] <= 1'b0;
                rsel       <= ~rsel;
            end
        end
    end

    for (genvar g = 0; g < SYM_BITS; g++) begin : g_rport
        assign rbits[g] = bank[rsel][raddr[g]];
    end

    AST_WRITE_FREE_BANK: assert property (@(posedge clk) disable iff (rst)
        we |-> !full[wsel]); // R8
    AST_READ_FULL_BANK: assert property (@(posedge clk) disable iff (rst)
        rd_done |-> full[rsel]); // R10
    AST_DONE_SETS_FULL: assert property (@(posedge clk) disable iff (rst)
        wr_done |=> full[$past(wsel)]); // R8

endmodule

// File: rtl/scppm_acc_map.sv
module scppm_acc_map
    import scppm_pkg::*;
#(
    parameter int CODE_BITS = 32,
    parameter int SYM_BITS  = 4,
    parameter int PERM_MULT = 13,
    parameter int AW        = $clog2(CODE_BITS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         rd_ok,
    output logic [SYM_BITS-1:0][AW-1:0]  raddr,
    input  logic [SYM_BITS-1:0]          rbits,
    output logic                         rd_done,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic [SYM_BITS-1:0]          out_sym
);

    localparam int SYMS = CODE_BITS / SYM_BITS;
    localparam int SW   = (SYMS > 1) ? $clog2(SYMS) : 1;

    logic [SW-1:0]     sidx;
    logic              acc;
    logic [SYM_BITS:0] chain;
    logic              fire;
    logic              last;

    assign out_valid = rd_ok;
    assign fire      = out_valid && out_ready;
    assign last      = (sidx == SW'(SYMS - 1));
    assign rd_done   = fire && last;
    assign chain[0]  = acc;

    for (genvar g = 0; g < SYM_BITS; g++) begin : g_slot_bit
        assign raddr[g] = AW'(perm_index(int'(sidx) * SYM_BITS + g,
                                         PERM_MULT, CODE_BITS));
        assign chain[g+1]              = chain[g] ^ rbits[g];
        assign out_sym[SYM_BITS-1-g]   = chain[g+1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sidx <= '0;
            acc  <= 1'b0;
        end else if (fire) begin
            if (last) begin
                sidx <= '0;
                acc  <= 1'b0;
            end else begin
                sidx <= sidx + SW'(1);
                acc  <= chain[SYM_BITS];
            end
        end
    end

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_sym)); // R9
    AST_BLOCK_START_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (sidx == '0) |-> (acc == 1'b0)); // R4
    AST_IDLE_AT_START: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (sidx == '0)); // R10

endmodule

// File: rtl/scppm_encoder.sv
module scppm_encoder
    import scppm_pkg::*;
#(
    parameter int INFO_BITS = 14,
    parameter int PPM_SLOTS = 16,
    parameter int PERM_MULT = 13
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic                         in_bit,
    input  logic                         in_sof,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic [$clog2(PPM_SLOTS)-1:0] out_sym
);

    localparam int SYM_BITS  = $clog2(PPM_SLOTS);
    localparam int CODE_BITS = int'(coded_len(INFO_BITS));
    localparam int AW        = $clog2(CODE_BITS);
    localparam int PW        = AW - 1;

    logic                        wr_ok;
    logic                        we;
    logic [PW-1:0]               waddr;
    cc_pair_t                    wpair;
    logic                        wr_done;
    logic [SYM_BITS-1:0][AW-1:0] raddr;
    logic [SYM_BITS-1:0]         rbits;
    logic                        rd_done;
    logic                        rd_ok;

    scppm_outer_enc #(
        .INFO_BITS (INFO_BITS),
        .PW        (PW)
    ) u_outer (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_bit   (in_bit),
        .in_sof   (in_sof),
        .wr_ok    (wr_ok),
        .we       (we),
        .waddr    (waddr),
        .wpair    (wpair),
        .wr_done  (wr_done)
    );

    scppm_ilv_store #(
        .CODE_BITS (CODE_BITS),
        .SYM_BITS  (SYM_BITS),
        .AW        (AW),
        .PW        (PW)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (we),
        .waddr   (waddr),
        .wpair   (wpair),
        .wr_done (wr_done),
        .wr_ok   (wr_ok),
        .raddr   (raddr),
        .rbits   (rbits),
        .rd_done (rd_done),
        .rd_ok   (rd_ok)
    );

    scppm_acc_map #(
        .CODE_BITS (CODE_BITS),
        .SYM_BITS  (SYM_BITS),
        .PERM_MULT (PERM_MULT),
        .AW        (AW)
    ) u_map (
        .clk       (clk),
        .rst       (rst),
        .rd_ok     (rd_ok),
        .raddr     (raddr),
        .rbits     (rbits),
        .rd_done   (rd_done),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_sym   (out_sym)
    );

    AST_OUT_FOLLOWS_BLOCK: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(wr_done)); // R10

endmodule

// File: tb/scppm_encoder_bench.sv
module scppm_encoder_bench;

    localparam int CLK_PERIOD = 10;
    localparam int K  = 14;
    localparam int M  = 16;
    localparam int A  = 13;
    localparam int SB = 4;
    localparam int N  = 2 * (K + 2);
    localparam int MAX_ITEMS = 8192;
    localparam int MAX_SYMS  = 4096;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic          in_ready;
    logic          in_bit;
    logic          in_sof;
    logic          out_valid;
    logic          out_ready;
    logic [SB-1:0] out_sym;

    bit  item_bit [MAX_ITEMS];
    bit  item_sof [MAX_ITEMS];
    int  exp_sym  [MAX_SYMS];
    int  n_items = 0;
    int  n_exp   = 0;
    int  pidx    = 0;
    int  acc_cnt = 0;
    int  cidx    = 0;
    int  tests   = 0;
    int  fails   = 0;
    bit  go      = 1'b0;
    bit  hold    = 1'b1;
    bit  rnd_mode = 1'b0;
    bit  done    = 1'b0;
    bit  fire    = 1'b0;
    bit  stall_prev = 1'b0;
    logic [SB-1:0] stall_sym;
    logic [15:0]   rlfsr = 16'hACE1;

    scppm_encoder #(
        .INFO_BITS (K),
        .PPM_SLOTS (M),
        .PERM_MULT (A)
    ) u_scppm_encoder (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_bit    (in_bit),
        .in_sof    (in_sof),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_sym   (out_sym)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic add_block(input bit [K-1:0] info, input int junk, input int sof_at);
        bit code [N];
        bit s1, s2, u, acc;
        bit av [N];
        int v;
        for (int i = 0; i < junk; i++) begin
            item_bit[n_items] = 1'b1;
            item_sof[n_items] = 1'b0;
            n_items++;
        end
        for (int t = 0; t < K; t++) begin
            item_bit[n_items] = info[t];
            item_sof[n_items] = (t == 0) || (t == sof_at);
            n_items++;
        end
        s1 = 1'b0;
        s2 = 1'b0;
        for (int t = 0; t < K + 2; t++) begin
            u = (t < K) ? info[t] : 1'b0;
            code[2*t]   = u ^ s1 ^ s2;
            code[2*t+1] = u ^ s2;
            s2 = s1;
            s1 = u;
        end
        acc = 1'b0;
        for (int j = 0; j < N; j++) begin
            acc = acc ^ code[(A * j) % N];
            av[j] = acc;
        end
        for (int s = 0; s < N / SB; s++) begin
            v = 0;
            for (int b = 0; b < SB; b++) v = v * 2 + int'(av[s*SB+b]);
            exp_sym[n_exp] = v;
            n_exp++;
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    // producer: drives at negedge, handshake completes at the following posedge
    initial begin
        in_valid = 1'b0;
        in_bit   = 1'b0;
        in_sof   = 1'b0;
        wait (go);
        forever begin
            @(negedge clk);
            if (fire) begin
                acc_cnt++;
                pidx++;
            end
            if (pidx < n_items) begin
                in_valid = 1'b1;
                in_bit   = item_bit[pidx];
                in_sof   = item_sof[pidx];
            end else begin
                in_valid = 1'b0;
                in_bit   = 1'b0;
                in_sof   = 1'b0;
            end
            fire = in_valid && in_ready;
        end
    end

    // consumer: sets out_ready at negedge and checks the symbol taken at the next posedge
    initial begin
        bit rdy;
        out_ready = 1'b0;
        wait (go);
        forever begin
            @(negedge clk);
            if (stall_prev) begin
                check(out_valid == 1'b1, "R9 valid held under stall", int'(out_valid), 1);
                check(out_sym == stall_sym, "R9 symbol held under stall", int'(out_sym), int'(stall_sym));
            end
            rlfsr = {rlfsr[14:0], rlfsr[15] ^ rlfsr[13] ^ rlfsr[12] ^ rlfsr[10]};
            rdy = !hold && (!rnd_mode || rlfsr[0] || rlfsr[3]);
            out_ready = rdy;
            stall_prev = out_valid && !rdy;
            stall_sym  = out_sym;
            if (out_valid && rdy) begin
                if (cidx >= n_exp) begin
                    check(1'b0, "R10 extra symbol", cidx, n_exp);
                end else begin
                    check(int'(out_sym) == exp_sym[cidx],
                          "R2 R3 R4 R5 R6 symbol value", int'(out_sym), exp_sym[cidx]);
                end
                cidx++;
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R10 watchdog: symbols out %0d expected %0d", cidx, n_exp);
            summary();
            $finish;
        end
    end

    initial begin
        bit [15:0] plfsr;
        rst = 1'b1;
        plfsr = 16'h1D2B;
        // first two blocks: no junk, used by the full-buffer stall test
        add_block(14'h2A5B, 0, -1);
        add_block(14'h1337, 0, -1);
        add_block('0, 3, -1);
        add_block('1, 0, 5);
        for (int i = 0; i < K; i++) begin
            add_block(14'(1) << i, (i % 5 == 0) ? 2 : 0, (i % 4 == 1) ? 7 : -1);
        end
        for (int i = 0; i < K; i++) begin
            for (int j = i + 1; j < K; j++) begin
                add_block((14'(1) << i) | (14'(1) << j), (j % 7 == 0) ? 3 : 0,
                          (i % 11 == 3) ? 5 : -1);
            end
        end
        for (int i = 0; i < 150; i++) begin
            plfsr = {plfsr[14:0], plfsr[15] ^ plfsr[13] ^ plfsr[12] ^ plfsr[10]};
            add_block(plfsr[13:0], (i % 7 == 0) ? 3 : 0, (i % 11 == 0) ? 9 : -1);
        end

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
        go = 1'b1;

        do begin
            @(negedge clk);
            #1;
        end while (acc_cnt < K);
        check(in_ready == 1'b0, "R7 tail cycle 1 ready low", int'(in_ready), 0);
        @(negedge clk);
        #1;
        check(in_ready == 1'b0, "R7 tail cycle 2 ready low", int'(in_ready), 0);
        @(negedge clk);
        #1;
        check(in_ready == 1'b1, "R7 ready back after tail", int'(in_ready), 1);

        repeat (60) @(negedge clk);
        #1;
        check(acc_cnt == 2 * K, "R8 bits accepted with output stalled", acc_cnt, 2 * K);
        check(in_ready == 1'b0, "R8 ready low with both banks full", int'(in_ready), 0);
        check(out_valid == 1'b1, "R10 first block offered", int'(out_valid), 1);
        check(int'(out_sym) == exp_sym[0], "R5 first symbol under stall", int'(out_sym), exp_sym[0]);
        hold = 1'b0;

        wait (cidx >= n_exp / 2);
        rnd_mode = 1'b1;
        wait (cidx >= n_exp);
        repeat (20) @(negedge clk);
        #1;
        check(cidx == n_exp, "R10 symbol count", cidx, n_exp);
        check(out_valid == 1'b0, "R10 idle after last block", int'(out_valid), 0);
        check(in_ready == 1'b1, "R6 ready while waiting for marker", int'(in_ready), 1);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule